// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This unit sits beside the DMA engine of a display controller. Each cycle it takes one-cycle event pulses: per-channel start of frame, end of frame, branch and input underrun; a bus error tagged with a channel number; and a few controller-wide events. It records them as sticky bits in two status words. The bits whose mask input is clear are ORed into a registered interrupt line. Software clears status bits by writing ones through a small write port. The mask bits arrive as plain inputs from the control registers.

The unit also keeps an interrupt ID. A qualifying event is an unmasked start-of-frame, end-of-frame or branch event, or any bus error. When one arrives while the interrupt line is low, the unit loads the frame ID of the channel that caused it. When one arrives while the line is already high, the ID is left alone and a sticky "subsequent interrupt" bit is set instead. Software can therefore tell the first cause apart from later ones.

Top module: `lcdirq_top`

## Requirements
- R1: After reset, both status words, the interrupt ID and the interrupt line are all zero.
- R2: Status word 0 sets these bits from its events: bit 0 last frame done, bit 1 ch0 start of frame, bit 2 bus error, bit 3 bias count, bit 4 ch0 underrun, bit 5 ch1 underrun, bit 6 output underrun, bit 7 quick-disable done, bit 8 ch0 end of frame, bit 9 ch0 branch, bit 10 subsequent interrupt, bit 11 read status, bit 12 command. A bit is visible on the status output the cycle after its pulse is sampled.
- R3: For channel ch from 1 to 6, status word 1 sets bit ch-1 on start of frame, bit ch+7 on end of frame, bit ch+15 on branch and bit ch+23 on input underrun. A ch1 underrun sets both bit 5 of word 0 and bit 24 of word 1.
- R4: The interrupt line is a registered OR of every status-1 bit with a clear matching mask1 bit and every status-0 bit in {0,1,4,5,6,7,8,9,11,12} with a clear matching mask0 bit. It follows status by one cycle.
- R5: A masked event still records its status bit. It neither raises the line nor counts as a qualifying event.
- R6: When the line is low and one or more qualifying events arrive, the frame ID of the lowest-numbered qualifying channel is loaded, and bit 10 is not set.
- R7: When the line is high, a qualifying event sets bit 10 and leaves the ID unchanged. Bit 10 stays set until software clears it.
- R8: A bus error sets bit 2 and loads the channel number into bits 30:28 whatever the masks, and follows the rule of R6/R7. Bit 2 does not drive the line.
- R9: A write with wr_sel=0 clears the status-0 bits that are one in wr_data[11:0]. Bit 12 cannot be cleared. Clearing bit 2 also zeroes bits 30:28.
- R10: A write with wr_sel=1 clears only the written-one bits inside mask 0x3E3F3F. Branch bit 16 and the underrun bits 24-29 cannot be cleared.
- R11: A 1-to-0 change of ctl_en sets bit 7. A 0-to-1 change does not.
- R12: An event and a clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable level |
| ev_sof | input | 7 | Start-of-frame pulse per channel |
| ev_eof | input | 7 | End-of-frame pulse per channel |
| ev_bs | input | 7 | Branch pulse per channel |
| ev_iu | input | 7 | Input underrun pulse per channel |
| ev_ber | input | 1 | Bus error pulse |
| ber_ch | input | 3 | Channel of the bus error |
| ev_ldd | input | 1 | Last frame done pulse |
| ev_abc | input | 1 | Bias count pulse |
| ev_ou | input | 1 | Output underrun pulse |
| ev_rdst | input | 1 | Read status pulse |
| ev_cmd | input | 1 | Command interrupt pulse |
| frame_id | input | 224 | Frame ID per channel, channel ch at [ch*32 +: 32] |
| mask0 | input | 13 | Masks for status word 0, same bit positions |
| mask1 | input | 30 | Masks for status word 1, same bit positions |
| wr_en | input | 1 | Clear-write strobe |
| wr_sel | input | 1 | 0 selects status word 0, 1 selects word 1 |
| wr_data | input | 30 | Ones clear bits |
| status0_o | output | 32 | Status word 0 |
| status1_o | output | 30 | Status word 1 |
| irq_id_o | output | 32 | Latched interrupt frame ID |
| irq_o | output | 1 | Interrupt line |

## Verification
Each event source is first fired with every mask set. This separates recording from signalling: status bits must appear while the line stays low. Single unmasked events then show the one-cycle lag of the line. Two qualifying channels fired together tell the lowest-numbered rule apart from a last-wins rule. Pairs of events, one masked and one unmasked, fired while the line is high separate ID hold from subsequent-interrupt setting. Clear writes with all ones expose exactly which bits are protected. A bus error, a clear in the same cycle as a set, and both directions of the enable change cover the remaining corners.

// File: rtl/lcdirq_pkg.sv
package lcdirq_pkg;
    localparam int S0_EVW  = 13;
    localparam int B_LDD   = 0;
    localparam int B_SOF0  = 1;
    localparam int B_BER   = 2;
    localparam int B_ABC   = 3;
    localparam int B_IU0   = 4;
    localparam int B_IU1   = 5;
    localparam int B_OU    = 6;
    localparam int B_QD    = 7;
    localparam int B_EOF0  = 8;
    localparam int B_BS0   = 9;
    localparam int B_SINT  = 10;
    localparam int B_RDST  = 11;
    localparam int B_CMD   = 12;
    localparam int BERCH_LO = 28;
    localparam int CLR0_W  = 12;
    // status-0 bits that may drive the interrupt line
    localparam logic [S0_EVW-1:0] SRC0 = 13'b1101111110011;
    // clearable bits of status word 1
    localparam logic [29:0] CLR1 = 30'h003E3F3F;
endpackage

// File: rtl/lcdirq_evmap.sv
module lcdirq_evmap #(
    parameter int NUM_CH = 7,
    parameter int S1_W   = NUM_CH + 23
) (
    input  logic [NUM_CH-1:0] sof,
    input  logic [NUM_CH-1:0] eof,
    input  logic [NUM_CH-1:0] bs,
    input  logic [NUM_CH-1:1] iu_hi,
    input  logic              msk_sof0,
    input  logic              msk_eof0,
    input  logic              msk_bs0,
    input  logic [S1_W-1:0]   mask1,
    output logic [S1_W-1:0]   set1,
    output logic [NUM_CH-1:0] qual
);
    logic [S1_W-1:0] sel;

    always_comb begin
        set1 = '0;
        for (int ch = 1; ch < NUM_CH; ch++) begin
            set1[ch-1]  = sof[ch];
            set1[ch+7]  = eof[ch];
            set1[ch+15] = bs[ch];
            set1[ch+23] = iu_hi[ch];
        end
    end

    always_comb begin
        qual    = '0;
        sel     = '0;
        qual[0] = (sof[0] & ~msk_sof0) | (eof[0] & ~msk_eof0) | (bs[0] & ~msk_bs0);
        for (int ch = 1; ch < NUM_CH; ch++) begin
            sel          = '0;
            sel[ch-1]    = 1'b1;
            sel[ch+7]    = 1'b1;
            sel[ch+15]   = 1'b1;
            qual[ch]     = |(set1 & ~mask1 & sel);
        end
    end
endmodule

// File: rtl/lcdirq_level.sv
module lcdirq_level
    import lcdirq_pkg::*;
#(
    parameter int S1_W = 30
) (
    input  logic [S0_EVW-1:0] s0,
    input  logic [S0_EVW-1:0] mask0,
    input  logic [S1_W-1:0]   s1,
    input  logic [S1_W-1:0]   mask1,
    output logic              level
);
    always_comb begin
        level = (|(s0 & ~mask0 & SRC0)) | (|(s1 & ~mask1));
    end
endmodule

// File: rtl/lcdirq_top.sv
module lcdirq_top
    import lcdirq_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32,
    parameter int S1_W   = NUM_CH + 23,
    parameter int CH_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_en,
    input  logic [NUM_CH-1:0]      ev_sof,
    input  logic [NUM_CH-1:0]      ev_eof,
    input  logic [NUM_CH-1:0]      ev_bs,
    input  logic [NUM_CH-1:0]      ev_iu,
    input  logic                   ev_ber,
    input  logic [CH_W-1:0]        ber_ch,
    input  logic                   ev_ldd,
    input  logic                   ev_abc,
    input  logic                   ev_ou,
    input  logic                   ev_rdst,
    input  logic                   ev_cmd,
    input  logic [NUM_CH*ID_W-1:0] frame_id,
    input  logic [S0_EVW-1:0]      mask0,
    input  logic [S1_W-1:0]        mask1,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [S1_W-1:0]        wr_data,
    output logic [31:0]            status0_o,
    output logic [S1_W-1:0]        status1_o,
    output logic [ID_W-1:0]        irq_id_o,
    output logic                   irq_o
);
    typedef struct packed {
        logic [31:0]     s0;
        logic [S1_W-1:0] s1;
        logic [ID_W-1:0] id;
        logic            irq;
        logic            en;
    } state_t;

    state_t q, d;

    logic [S1_W-1:0]   set1;
    logic [NUM_CH-1:0] qual_ev;
    logic [NUM_CH-1:0] qual_all;
    logic              level;
    logic [ID_W-1:0]   pick_id;
    logic [S0_EVW-1:0] set0;

    lcdirq_evmap #(.NUM_CH(NUM_CH), .S1_W(S1_W)) u_map (
        .sof      (ev_sof),
        .eof      (ev_eof),
        .bs       (ev_bs),
        .iu_hi    (ev_iu[NUM_CH-1:1]),
        .msk_sof0 (mask0[B_SOF0]),
        .msk_eof0 (mask0[B_EOF0]),
        .msk_bs0  (mask0[B_BS0]),
        .mask1    (mask1),
        .set1     (set1),
        .qual     (qual_ev)
    );

    lcdirq_level #(.S1_W(S1_W)) u_lvl (
        .s0    (q.s0[S0_EVW-1:0]),
        .mask0 (mask0),
        .s1    (q.s1),
        .mask1 (mask1),
        .level (level)
    );

    always_comb begin
        set0          = '0;
        set0[B_LDD]   = ev_ldd;
        set0[B_SOF0]  = ev_sof[0];
        set0[B_ABC]   = ev_abc;
        set0[B_IU0]   = ev_iu[0];
        set0[B_IU1]   = ev_iu[1];
        set0[B_OU]    = ev_ou;
        set0[B_QD]    = q.en & ~ctl_en;
        set0[B_EOF0]  = ev_eof[0];
        set0[B_BS0]   = ev_bs[0];
        set0[B_RDST]  = ev_rdst;
        set0[B_CMD]   = ev_cmd;
    end

    always_comb begin
        qual_all = qual_ev;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ev_ber && (ber_ch == CH_W'(ch))) qual_all[ch] = 1'b1;
        end
        pick_id = '0;
        for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
            if (qual_all[ch]) pick_id = frame_id[ch*ID_W +: ID_W];
        end
    end

    always_comb begin
        d = q;
        // software clears first, so same-cycle events win
        if (wr_en && !wr_sel) begin
            d.s0[CLR0_W-1:0] = q.s0[CLR0_W-1:0] & ~wr_data[CLR0_W-1:0];
            if (wr_data[B_BER]) d.s0[BERCH_LO +: CH_W] = '0;
        end
        if (wr_en && wr_sel) begin
            d.s1 = q.s1 & ~(wr_data & CLR1[S1_W-1:0]);
        end
        d.s0[S0_EVW-1:0] = d.s0[S0_EVW-1:0] | set0;
        d.s1             = d.s1 | set1;
        if (ev_ber) begin
            d.s0[B_BER]              = 1'b1;
            d.s0[BERCH_LO +: CH_W]   = ber_ch;
        end
        if (|qual_all) begin
            if (q.irq) d.s0[B_SINT] = 1'b1;
            else       d.id         = pick_id;
        end
        d.irq = level;
        d.en  = ctl_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status0_o = q.s0;
    assign status1_o = q.s1;
    assign irq_id_o  = q.id;
    assign irq_o     = q.irq;

    AST_BER_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ber |=> (status0_o[B_BER] && status0_o[BERCH_LO +: CH_W] == $past(ber_ch))); // R8
    AST_QD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && !ctl_en) |=> status0_o[B_QD]); // R11
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> $stable(irq_id_o)); // R7
    AST_LINE_S1: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status1_o & ~mask1)) |=> irq_o); // R4
    AST_SINT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status0_o[B_SINT] && !(wr_en && !wr_sel && wr_data[B_SINT])) |=> status0_o[B_SINT]); // R7
    AST_BS1_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        status1_o[16] |=> status1_o[16]); // R10
endmodule

// File: tb/sim_lcdirq_top.sv
module sim_lcdirq_top;
    localparam int NCH = 7;
    localparam int IDW = 32;
    localparam int S1W = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_en = 1'b0;
    logic [NCH-1:0] ev_sof = '0, ev_eof = '0, ev_bs = '0, ev_iu = '0;
    logic ev_ber = 1'b0;
    logic [2:0] ber_ch = '0;
    logic ev_ldd = 0, ev_abc = 0, ev_ou = 0, ev_rdst = 0, ev_cmd = 0;
    logic [NCH*IDW-1:0] frame_id;
    logic [12:0] mask0 = '1;
    logic [S1W-1:0] mask1 = '1;
    logic wr_en = 0, wr_sel = 0;
    logic [S1W-1:0] wr_data = '0;
    logic [31:0] status0_o;
    logic [S1W-1:0] status1_o;
    logic [IDW-1:0] irq_id_o;
    logic irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lcdirq_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bs(ev_bs), .ev_iu(ev_iu),
        .ev_ber(ev_ber), .ber_ch(ber_ch), .ev_ldd(ev_ldd), .ev_abc(ev_abc),
        .ev_ou(ev_ou), .ev_rdst(ev_rdst), .ev_cmd(ev_cmd), .frame_id(frame_id),
        .mask0(mask0), .mask1(mask1), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .status0_o(status0_o), .status1_o(status1_o),
        .irq_id_o(irq_id_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // inputs were set at a negedge; advance one edge, release pulses
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ev_sof = '0; ev_eof = '0; ev_bs = '0; ev_iu = '0; ev_ber = 0;
        ev_ldd = 0; ev_abc = 0; ev_ou = 0; ev_rdst = 0; ev_cmd = 0;
        wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    task automatic clr(input logic sel, input logic [S1W-1:0] data);
        wr_en = 1; wr_sel = sel; wr_data = data;
        step();
    endtask

    task automatic t_reset();
        chk("R1 status0", status0_o, 32'h0);
        chk("R1 status1", {2'b0, status1_o}, 32'h0);
        chk("R1 id", irq_id_o, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_masked_s0();
        ev_ldd = 1; ev_abc = 1; ev_ou = 1; ev_rdst = 1; ev_cmd = 1;
        step();
        chk("R2 status0 bits", status0_o, 32'h0000_1849);
        step();
        chk("R5 masked irq low", {31'b0, irq_o}, 32'h0);
        chk("R5 masked id", irq_id_o, 32'h0);
        clr(1'b0, 30'hFFF);
        chk("R9 clear keeps bit12", status0_o, 32'h0000_1000);
    endtask

    task automatic t_status1();
        ev_sof[3] = 1; ev_eof[5] = 1; ev_bs[2] = 1; ev_bs[1] = 1; ev_iu[4] = 1;
        step();
        chk("R3 status1 map", {2'b0, status1_o}, 32'h0803_1004);
        ev_iu[1:0] = 2'b11;
        step();
        chk("R3 iu0/iu1 word0", status0_o, 32'h0000_1030);
        chk("R3 iu1 word1", {2'b0, status1_o}, 32'h0903_1004);
        clr(1'b1, '1);
        chk("R10 protected bits", {2'b0, status1_o}, 32'h0901_0000);
        clr(1'b0, 30'hFFF);
        chk("R9 clear iu", status0_o, 32'h0000_1000);
    endtask

    task automatic t_latch_sint();
        mask1[11] = 0;           // eof ch4
        mask1[1]  = 0;           // sof ch2
        ev_eof[4] = 1; ev_sof[2] = 1;
        step();
        chk("R6 lowest channel id", irq_id_o, 32'hA000_0002);
        chk("R6 no sint", {31'b0, status0_o[10]}, 32'h0);
        chk("R4 irq lags", {31'b0, irq_o}, 32'h0);
        step();
        chk("R4 irq raised", {31'b0, irq_o}, 32'h1);
        ev_bs[3] = 1;            // masked while high
        step();
        chk("R5 masked no sint", {31'b0, status0_o[10]}, 32'h0);
        ev_eof[4] = 1; frame_id[5*IDW +: IDW] = 32'hA000_0005;
        step();
        chk("R7 sint set", status0_o, 32'h0000_1400);
        chk("R7 id held", irq_id_o, 32'hA000_0002);
        ev_ber = 1; ber_ch = 3'd5;
        step();
        chk("R8 ber field", status0_o, 32'h5000_1404);
        chk("R8 id held", irq_id_o, 32'hA000_0002);
        clr(1'b0, 30'h004);
        chk("R9 ber clear field", status0_o, 32'h0000_1400);
        clr(1'b0, 30'h400);
        chk("R7 sint cleared", status0_o, 32'h0000_1000);
        clr(1'b1, '1);
        step();
        chk("R4 irq dropped", {31'b0, irq_o}, 32'h0);
        mask1 = '1;
    endtask

    task automatic t_ber_low();
        ev_ber = 1; ber_ch = 3'd6;
        step();
        chk("R8 ber latches id", irq_id_o, 32'hA000_0006);
        step();
        chk("R8 ber no line", {31'b0, irq_o}, 32'h0);
        clr(1'b0, 30'h004);
    endtask

    task automatic t_qd();
        mask0[7] = 0;
        ctl_en = 1;
        step();
        chk("R11 rise no qd", status0_o, 32'h0000_1000);
        ctl_en = 0;
        step();
        chk("R11 fall qd", status0_o, 32'h0000_1080);
        step();
        chk("R4 qd irq", {31'b0, irq_o}, 32'h1);
        clr(1'b0, 30'h080);
        step();
        chk("R4 qd irq cleared", {31'b0, irq_o}, 32'h0);
        mask0 = '1;
    endtask

    task automatic t_set_wins();
        ev_ldd = 1; wr_en = 1; wr_sel = 0; wr_data = 30'h001;
        step();
        chk("R12 set wins", status0_o, 32'h0000_1001);
        clr(1'b0, 30'h001);
        chk("R12 later clear", status0_o, 32'h0000_1000);
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) frame_id[ch*IDW +: IDW] = 32'hA000_0000 + ch;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_masked_s0();
        t_status1();
        t_latch_sint();
        t_ber_low();
        t_qd();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule